// File: doc/BRIEF.md
# Write-Only I2C Control Register Target for a Backlight Controller

This block is an I2C target that only takes writes. It sits behind the two bus lines of a backlight controller. It oversamples SCL and SDA with the system clock through a two-flop synchronizer. It recognises START, STOP and repeated START, shifts in bytes and pulls SDA low for the acknowledge bit. It then turns the byte stream into register writes and a small set of one-cycle event pulses. The target never returns read data. The only thing it drives onto the bus is the acknowledge low level, through the open-drain request `sda_pull`.

A transaction opens with the address byte. It continues with any number of pairs, each made of a select byte and a data byte, and it ends at STOP. The select byte is used for a single data byte only. The select byte itself also controls power state: selecting register 0 enters shutdown, and selecting any other register leaves it. A strap input is sampled in the first clock after reset release and picks one of two 7-bit addresses.

The link state machine has eight states:

| State | Meaning |
|---|---|
| `ST_IDLE` | Bus idle. |
| `ST_ADDR` | Shifting in the address byte. |
| `ST_ADDR_ACK` | Acknowledging a matching address. |
| `ST_SEL` | Shifting in a select byte. |
| `ST_SEL_ACK` | Acknowledging the select byte. |
| `ST_DATA` | Shifting in a data byte. |
| `ST_DATA_ACK` | Acknowledging the data byte. |
| `ST_SKIP` | Another target was addressed; the bus is ignored. |

Transitions:
- START from any state goes to `ST_ADDR`. STOP from any state goes to `ST_IDLE`.
- `ST_ADDR`, after eight bits, goes to `ST_ADDR_ACK` on a match and to `ST_SKIP` otherwise.
- `ST_SEL` goes to `ST_SEL_ACK`, and `ST_DATA` goes to `ST_DATA_ACK`, at the SCL fall after the eighth bit.
- Each acknowledge state moves on at the SCL fall that ends the ninth bit: `ST_ADDR_ACK` and `ST_DATA_ACK` go to `ST_SEL`, and `ST_SEL_ACK` goes to `ST_DATA`.

Top module: `bl_i2c_wr_slave`

## Requirements
- R1: The target answers 7-bit address 0x39 (write byte 0x72) when `addr_strap` is low in the first clock after reset release, and 0x3A (0x74) when it is high. Later changes of `addr_strap` have no effect until the next reset.
- R2: The R/W bit (bit 0 of the address byte) is ignored: address bytes 0x73 and 0x75 update registers exactly as 0x72 and 0x74 do.
- R3: After the address byte, bytes alternate select, data, select, data until STOP. The register number is bits 3:0 of the select byte. A select byte applies to one data byte only, so the byte that follows a data byte is always taken as a select.
- R4: After a matching address, `sda_pull` is high during the ninth clock of that byte and of every later byte of the frame. After a non-matching address it stays low until the next START. SDA is never pulled at any other time.
- R5: A data byte is stored into the selected register when it is acknowledged. The outputs show the following bits, and all other bits read as zero:
  - registers 1 to 7: bits 4:0, on `led_level`, `dim_up_tgt`, `dim_dn_tgt`, `dim_step_time`, `pwm_a`, `pwm_b` and `pwm_c`;
  - register 8: bit 7 on `sense_en` and bits 4:0 on `sense_gain`;
  - register 9: bits 3:0 on `sense_floor`;
  - register 10: bits 5:0 on `sense_rate`.
- R6: Selecting register 0 while active sets `powered_down` and gives one `sdn_pulse`. Selecting it again while already shut down gives no pulse. The data byte after a register 0 select is acknowledged and discarded.
- R7: Selecting any register from 1 to 15 while shut down clears `powered_down` and gives one `wake_pulse`. No pulse is given when the block is already active.
- R8: Data bytes for registers 11 to 15 (reserved and test) are acknowledged and change no output.
- R9: A data write to register 1 gives a one-cycle `cur_upd_pulse`. A data write to register 4 gives a one-cycle `dim_start_pulse`.
- R10: After reset all register outputs are zero, `powered_down` is 1, and `bus_busy` and `sda_pull` are 0.
- R11: A repeated START returns the target to address reception. A select byte that is still waiting for its data byte is dropped.
- R12: `bus_busy` rises when the target's own address is matched. It stays high, across repeated STARTs, until STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad |
| addr_strap | input | 1 | Address select, sampled once after reset |
| sda_pull | output | 1 | Request to pull SDA low (acknowledge) |
| bus_busy | output | 1 | Own frame in progress |
| powered_down | output | 1 | Shutdown state |
| sdn_pulse | output | 1 | Entered shutdown |
| wake_pulse | output | 1 | Left shutdown |
| cur_upd_pulse | output | 1 | Current level register written |
| dim_start_pulse | output | 1 | Dimming step time written, start ramp |
| led_level | output | 5 | Register 1 field |
| dim_up_tgt | output | 5 | Register 2 field |
| dim_dn_tgt | output | 5 | Register 3 field |
| dim_step_time | output | 5 | Register 4 field |
| pwm_a | output | 5 | Register 5 field |
| pwm_b | output | 5 | Register 6 field |
| pwm_c | output | 5 | Register 7 field |
| sense_en | output | 1 | Register 8 bit 7 |
| sense_gain | output | 5 | Register 8 bits 4:0 |
| sense_floor | output | 4 | Register 9 field |
| sense_rate | output | 6 | Register 10 field |

## Verification
A wrong link state shows up on `sda_pull` within the same byte, at the ninth clock: an acknowledge goes missing, appears after a foreign address, or falls on the wrong bit. A lost or kept select byte shows up in the next register write, one byte later, when the wrong output field changes. It can also show as a `wake_pulse` or `sdn_pulse` that appears or is missing. Power state errors appear on `powered_down` within two clocks of the select byte's acknowledge.

// File: rtl/i2cw_pkg.sv
package i2cw_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_SEL,
        ST_SEL_ACK,
        ST_DATA,
        ST_DATA_ACK,
        ST_SKIP
    } link_state_t;

    localparam int BYTE_W    = 8;
    localparam int ADDR_W    = 7;
    localparam int LIVE_REGS = 10;

    // visible bits kept for each live register (0 = no storage)
    function automatic int reg_width(input int idx);
        if (idx >= 1 && idx <= 7) return 5;
        if (idx == 8)             return 6;
        if (idx == 9)             return 4;
        if (idx == 10)            return 6;
        return 0;
    endfunction

    // offset of a register's field in the packed live vector
    function automatic int reg_base(input int idx);
        int acc;
        acc = 0;
        for (int k = 1; k < idx; k++) acc += reg_width(k);
        return acc;
    endfunction

    localparam int LIVE_W = reg_base(LIVE_REGS + 1);

endpackage

// File: rtl/i2cw_sync.sv
module i2cw_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic sda_hi,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_ff, sda_ff;
    logic              scl_d, sda_d;
    logic              scl_s, sda_s;

    assign scl_s = scl_ff[STAGES-1];
    assign sda_s = sda_ff[STAGES-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_ff <= '1;
            sda_ff <= '1;
            scl_d  <= 1'b1;
            sda_d  <= 1'b1;
        end else begin
            scl_ff <= {scl_ff[STAGES-2:0], scl_in};
            sda_ff <= {sda_ff[STAGES-2:0], sda_in};
            scl_d  <= scl_s;
            sda_d  <= sda_s;
        end
    end

    assign sda_hi    = sda_s;
    assign scl_rise  = scl_s & ~scl_d;
    assign scl_fall  = ~scl_s & scl_d;
    assign start_det = scl_s & scl_d & sda_d & ~sda_s;
    assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/i2cw_link.sv
module i2cw_link
    import i2cw_pkg::*;
#(
    parameter int BW = BYTE_W,
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sda_hi,
    input  logic          scl_rise,
    input  logic          scl_fall,
    input  logic          start_det,
    input  logic          stop_det,
    input  logic [AW-1:0] own_addr,
    output logic          sda_pull,
    output logic          sel_evt,
    output logic          data_evt,
    output logic [BW-1:0] rx_byte,
    output logic          bus_busy
);
    localparam int CNT_W = $clog2(BW + 1);

    link_state_t      state, nxt;
    logic [CNT_W-1:0] bit_cnt;
    logic [BW-1:0]    shreg;
    logic             got_byte;
    logic             shifting;

    assign got_byte = (bit_cnt == CNT_W'(BW));
    assign shifting = state inside {ST_ADDR, ST_SEL, ST_DATA};
    assign rx_byte  = shreg;

    always_comb begin
        nxt = state;
        if (stop_det) begin
            nxt = ST_IDLE;
        end else if (start_det) begin
            nxt = ST_ADDR;
        end else begin
            unique case (state)
                ST_IDLE, ST_SKIP: nxt = state;
                ST_ADDR:
                    if (scl_fall && got_byte)
                        nxt = (shreg[BW-1:1] == own_addr) ? ST_ADDR_ACK : ST_SKIP;
                ST_SEL:      if (scl_fall && got_byte) nxt = ST_SEL_ACK;
                ST_DATA:     if (scl_fall && got_byte) nxt = ST_DATA_ACK;
                ST_ADDR_ACK: if (scl_fall) nxt = ST_SEL;
                ST_SEL_ACK:  if (scl_fall) nxt = ST_DATA;
                ST_DATA_ACK: if (scl_fall) nxt = ST_SEL;
                default:     nxt = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // bit shifter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            shreg   <= '0;
        end else if (start_det || (nxt != state)) begin
            bit_cnt <= '0;
        end else if (scl_rise && shifting && !got_byte) begin
            shreg   <= {shreg[BW-2:0], sda_hi};
            bit_cnt <= bit_cnt + 1'b1;
        end
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sda_pull <= 1'b0;
            sel_evt  <= 1'b0;
            data_evt <= 1'b0;
            bus_busy <= 1'b0;
        end else begin
            sda_pull <= nxt inside {ST_ADDR_ACK, ST_SEL_ACK, ST_DATA_ACK};
            sel_evt  <= (state == ST_SEL)  && (nxt == ST_SEL_ACK);
            data_evt <= (state == ST_DATA) && (nxt == ST_DATA_ACK);
            if (stop_det)
                bus_busy <= 1'b0;
            else if (state == ST_ADDR && nxt == ST_ADDR_ACK)
                bus_busy <= 1'b1;
        end
    end
endmodule

// File: rtl/i2cw_regbank.sv
module i2cw_regbank
    import i2cw_pkg::*;
#(
    parameter int NUM_REGS   = 16,
    parameter int LEVEL_REG  = 1,
    parameter int DIM_GO_REG = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_evt,
    input  logic              data_evt,
    input  logic [BYTE_W-1:0] rx_byte,
    output logic [LIVE_W-1:0] live_q,
    output logic              powered_down,
    output logic              sdn_pulse,
    output logic              wake_pulse,
    output logic              cur_upd_pulse,
    output logic              dim_start_pulse
);
    localparam int SEL_W = $clog2(NUM_REGS);

    logic [SEL_W-1:0] sel_q;
    logic [SEL_W-1:0] sel_in;

    assign sel_in = rx_byte[SEL_W-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q           <= '0;
            powered_down    <= 1'b1;
            sdn_pulse       <= 1'b0;
            wake_pulse      <= 1'b0;
            cur_upd_pulse   <= 1'b0;
            dim_start_pulse <= 1'b0;
        end else begin
            sdn_pulse       <= 1'b0;
            wake_pulse      <= 1'b0;
            cur_upd_pulse   <= data_evt && (sel_q == SEL_W'(LEVEL_REG));
            dim_start_pulse <= data_evt && (sel_q == SEL_W'(DIM_GO_REG));
            if (sel_evt) begin
                sel_q <= sel_in;
                if (sel_in == '0) begin
                    if (!powered_down) begin
                        powered_down <= 1'b1;
                        sdn_pulse    <= 1'b1;
                    end
                end else if (powered_down) begin
                    powered_down <= 1'b0;
                    wake_pulse   <= 1'b1;
                end
            end
        end
    end

    for (genvar g = 1; g <= LIVE_REGS; g++) begin : g_reg
        localparam int W = reg_width(g);
        localparam int B = reg_base(g);
        logic [W-1:0] q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                q <= '0;
            end else if (data_evt && sel_q == SEL_W'(g)) begin
                if (g == 8) q <= W'({rx_byte[7], rx_byte[4:0]});
                else        q <= rx_byte[W-1:0];
            end
        end
        assign live_q[B +: W] = q;
    end
endmodule

// File: rtl/bl_i2c_wr_slave.sv
module bl_i2c_wr_slave
    import i2cw_pkg::*;
#(
    parameter logic [ADDR_W-1:0] ADDR_LO     = 7'h39,
    parameter logic [ADDR_W-1:0] ADDR_HI     = 7'h3A,
    parameter int                SYNC_STAGES = 2,
    parameter int                NUM_REGS    = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_in,
    input  logic       sda_in,
    input  logic       addr_strap,
    output logic       sda_pull,
    output logic       bus_busy,
    output logic       powered_down,
    output logic       sdn_pulse,
    output logic       wake_pulse,
    output logic       cur_upd_pulse,
    output logic       dim_start_pulse,
    output logic [4:0] led_level,
    output logic [4:0] dim_up_tgt,
    output logic [4:0] dim_dn_tgt,
    output logic [4:0] dim_step_time,
    output logic [4:0] pwm_a,
    output logic [4:0] pwm_b,
    output logic [4:0] pwm_c,
    output logic       sense_en,
    output logic [4:0] sense_gain,
    output logic [3:0] sense_floor,
    output logic [5:0] sense_rate
);
    logic              sda_hi, scl_rise, scl_fall, start_det, stop_det;
    logic              sel_evt, data_evt;
    logic [BYTE_W-1:0] rx_byte;
    logic [LIVE_W-1:0] live_q;
    logic              strap_q, strap_done;
    logic [ADDR_W-1:0] own_addr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            strap_q    <= 1'b0;
            strap_done <= 1'b0;
        end else if (!strap_done) begin
            strap_q    <= addr_strap;
            strap_done <= 1'b1;
        end
    end

    assign own_addr = strap_q ? ADDR_HI : ADDR_LO;

    i2cw_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
        .sda_hi(sda_hi), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    i2cw_link link_i (
        .clk(clk), .rst_n(rst_n), .sda_hi(sda_hi), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
        .own_addr(own_addr), .sda_pull(sda_pull), .sel_evt(sel_evt),
        .data_evt(data_evt), .rx_byte(rx_byte), .bus_busy(bus_busy)
    );

    i2cw_regbank #(.NUM_REGS(NUM_REGS)) bank_i (
        .clk(clk), .rst_n(rst_n), .sel_evt(sel_evt), .data_evt(data_evt),
        .rx_byte(rx_byte), .live_q(live_q), .powered_down(powered_down),
        .sdn_pulse(sdn_pulse), .wake_pulse(wake_pulse),
        .cur_upd_pulse(cur_upd_pulse), .dim_start_pulse(dim_start_pulse)
    );

    assign led_level     = live_q[reg_base(1) +: 5];
    assign dim_up_tgt    = live_q[reg_base(2) +: 5];
    assign dim_dn_tgt    = live_q[reg_base(3) +: 5];
    assign dim_step_time = live_q[reg_base(4) +: 5];
    assign pwm_a         = live_q[reg_base(5) +: 5];
    assign pwm_b         = live_q[reg_base(6) +: 5];
    assign pwm_c         = live_q[reg_base(7) +: 5];
    assign sense_gain    = live_q[reg_base(8) +: 5];
    assign sense_en      = live_q[reg_base(8) + 5];
    assign sense_floor   = live_q[reg_base(9) +: 4];
    assign sense_rate    = live_q[reg_base(10) +: 6];
endmodule

// File: rtl/bl_i2c_wr_slave_chk.sv
module bl_i2c_wr_slave_chk (
    input logic clk,
    input logic rst_n,
    input logic sda_pull,
    input logic bus_busy,
    input logic powered_down,
    input logic sdn_pulse,
    input logic wake_pulse,
    input logic cur_upd_pulse,
    input logic dim_start_pulse
);
    assert_ack_in_frame_R4: assert property (@(posedge clk) disable iff (!rst_n)
        sda_pull |-> bus_busy);

    assert_sdn_edge_R6: assert property (@(posedge clk) disable iff (!rst_n)
        sdn_pulse |-> (powered_down && !$past(powered_down)));

    assert_wake_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wake_pulse |-> (!powered_down && $past(powered_down)));

    assert_power_pulse_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sdn_pulse, wake_pulse}));

    assert_upd_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cur_upd_pulse |=> !cur_upd_pulse);

    assert_dim_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        dim_start_pulse |=> !dim_start_pulse);
endmodule

bind bl_i2c_wr_slave bl_i2c_wr_slave_chk chk_i (
    .clk(clk), .rst_n(rst_n), .sda_pull(sda_pull), .bus_busy(bus_busy),
    .powered_down(powered_down), .sdn_pulse(sdn_pulse), .wake_pulse(wake_pulse),
    .cur_upd_pulse(cur_upd_pulse), .dim_start_pulse(dim_start_pulse)
);

// File: tb/bl_i2c_wr_slave_tb_top.sv
module bl_i2c_wr_slave_tb_top;
    localparam int Q = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic strap = 1'b0;
    logic sda_line;

    logic sda_pull, bus_busy, powered_down, sdn_pulse, wake_pulse, cur_upd_pulse, dim_start_pulse;
    logic [4:0] led_level, dim_up_tgt, dim_dn_tgt, dim_step_time, pwm_a, pwm_b, pwm_c, sense_gain;
    logic sense_en;
    logic [3:0] sense_floor;
    logic [5:0] sense_rate;

    int checks = 0, failures = 0;
    int n_sdn = 0, n_wake = 0, n_upd = 0, n_dim = 0;
    bit done = 0;
    logic [7:0] mdl [16];

    always #4 clk = ~clk;
    assign sda_line = sda_m & ~sda_pull;

    bl_i2c_wr_slave dut_i (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_line), .addr_strap(strap),
        .sda_pull(sda_pull), .bus_busy(bus_busy), .powered_down(powered_down),
        .sdn_pulse(sdn_pulse), .wake_pulse(wake_pulse), .cur_upd_pulse(cur_upd_pulse),
        .dim_start_pulse(dim_start_pulse), .led_level(led_level), .dim_up_tgt(dim_up_tgt),
        .dim_dn_tgt(dim_dn_tgt), .dim_step_time(dim_step_time), .pwm_a(pwm_a), .pwm_b(pwm_b),
        .pwm_c(pwm_c), .sense_en(sense_en), .sense_gain(sense_gain),
        .sense_floor(sense_floor), .sense_rate(sense_rate)
    );

    always @(posedge clk) begin
        if (sdn_pulse)       n_sdn++;
        if (wake_pulse)      n_wake++;
        if (cur_upd_pulse)   n_upd++;
        if (dim_start_pulse) n_dim++;
    end

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic waitq(input int n);
        repeat (n * Q) @(negedge clk);
    endtask

    function automatic logic [50:0] act_vec();
        return {led_level, dim_up_tgt, dim_dn_tgt, dim_step_time, pwm_a, pwm_b, pwm_c,
                sense_en, sense_gain, sense_floor, sense_rate};
    endfunction

    // expected fields from the R5 masks
    function automatic logic [50:0] exp_vec();
        return {mdl[1][4:0], mdl[2][4:0], mdl[3][4:0], mdl[4][4:0], mdl[5][4:0],
                mdl[6][4:0], mdl[7][4:0], mdl[8][7], mdl[8][4:0], mdl[9][3:0], mdl[10][5:0]};
    endfunction

    task automatic do_start();
        sda_m = 1'b0; waitq(1); scl_m = 1'b0; waitq(1);
    endtask

    task automatic do_rstart();
        sda_m = 1'b1; waitq(1); scl_m = 1'b1; waitq(1);
        sda_m = 1'b0; waitq(1); scl_m = 1'b0; waitq(1);
    endtask

    task automatic do_stop();
        sda_m = 1'b0; waitq(1); scl_m = 1'b1; waitq(1); sda_m = 1'b1; waitq(2);
    endtask

    task automatic send_byte(input logic [7:0] b, input bit exp_ack, input string req);
        logic acked;
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; waitq(1); scl_m = 1'b1; waitq(2); scl_m = 1'b0; waitq(1);
        end
        sda_m = 1'b1; waitq(1); scl_m = 1'b1; waitq(1);
        acked = ~sda_line;
        waitq(1); scl_m = 1'b0; waitq(1);
        chk(req, acked, exp_ack);
    endtask

    task automatic pair(input logic [7:0] sel, input logic [7:0] dat);
        send_byte(sel, 1'b1, "R4 select ack");
        send_byte(dat, 1'b1, "R4 data ack");
        if (sel[3:0] >= 1 && sel[3:0] <= 10) mdl[sel[3:0]] = dat;
    endtask

    task automatic do_reset(input logic s);
        strap = s; rst_n = 1'b0; waitq(2); rst_n = 1'b1; waitq(1);
        for (int i = 0; i < 16; i++) mdl[i] = 8'h00;
    endtask

    initial begin : main
        int w0, u0, d0, s0;
        do_reset(1'b0);
        // R10 reset state
        chk("R10 fields", act_vec(), 0);
        chk("R10 powered_down", powered_down, 1);
        chk("R10 busy", bus_busy, 0);
        chk("R10 sda_pull", sda_pull, 0);

        // R1 address 0x72 with strap low, R12 busy, R7 wake, R9 level pulse
        w0 = n_wake; u0 = n_upd;
        do_start();
        send_byte(8'h72, 1'b1, "R1 own address ack");
        chk("R12 busy after match", bus_busy, 1);
        pair(8'h01, 8'h15);
        do_stop();
        chk("R12 busy after stop", bus_busy, 0);
        chk("R5 level stored", act_vec(), exp_vec());
        chk("R7 wake pulse", n_wake - w0, 1);
        chk("R7 powered_down cleared", powered_down, 0);
        chk("R9 level pulse", n_upd - u0, 1);

        // R5 sweep: all ones, then an arithmetic pattern
        w0 = n_wake; u0 = n_upd; d0 = n_dim;
        for (int pass = 0; pass < 2; pass++) begin
            do_start();
            send_byte(8'h72, 1'b1, "R1 ack");
            for (int r = 1; r <= 10; r++)
                pair(8'(r), (pass == 0) ? 8'hFF : 8'((r * 29 + 3) ^ (pass * 8'h5A)));
            do_stop();
            chk("R5 masked fields", act_vec(), exp_vec());
        end
        chk("R9 level pulses", n_upd - u0, 2);
        chk("R9 dim start pulses", n_dim - d0, 2);
        chk("R7 no wake while active", n_wake - w0, 0);

        // R3 select not kept: byte after data is a new select
        do_start();
        send_byte(8'h72, 1'b1, "R1 ack");
        pair(8'h05, 8'h03);
        pair(8'h06, 8'h09);
        do_stop();
        chk("R3 alternation", act_vec(), exp_vec());

        // R2 read bit treated as write
        do_start();
        send_byte(8'h73, 1'b1, "R2 read-form address ack");
        pair(8'h07, 8'h1A);
        do_stop();
        chk("R2 read treated as write", act_vec(), exp_vec());

        // R1/R4 foreign address: no ack, nothing changes
        do_start();
        send_byte(8'h74, 1'b0, "R4 no ack foreign address");
        send_byte(8'h07, 1'b0, "R4 no ack after mismatch");
        send_byte(8'h02, 1'b0, "R4 no ack after mismatch");
        chk("R12 busy stays low", bus_busy, 0);
        do_stop();
        chk("R1 foreign frame ignored", act_vec(), exp_vec());

        // R8 reserved and test registers
        do_start();
        send_byte(8'h72, 1'b1, "R1 ack");
        pair(8'h0B, 8'hAA);
        pair(8'h0D, 8'h12);
        pair(8'h0F, 8'h55);
        do_stop();
        chk("R8 reserved discarded", act_vec(), exp_vec());

        // R6 shutdown, repeated shutdown, R7 wake
        s0 = n_sdn; w0 = n_wake;
        do_start();
        send_byte(8'h72, 1'b1, "R1 ack");
        pair(8'h00, 8'h1F);
        do_stop();
        chk("R6 powered_down set", powered_down, 1);
        chk("R6 one shutdown pulse", n_sdn - s0, 1);
        chk("R6 data discarded", act_vec(), exp_vec());
        do_start();
        send_byte(8'h72, 1'b1, "R1 ack");
        pair(8'h00, 8'h00);
        do_stop();
        chk("R6 no pulse when already down", n_sdn - s0, 1);
        do_start();
        send_byte(8'h72, 1'b1, "R1 ack");
        pair(8'h09, 8'h05);
        do_stop();
        chk("R7 wake pulse", n_wake - w0, 1);
        chk("R7 powered_down cleared", powered_down, 0);
        chk("R5 floor stored", act_vec(), exp_vec());

        // R11 repeated start drops pending select
        do_start();
        send_byte(8'h72, 1'b1, "R1 ack");
        send_byte(8'h06, 1'b1, "R4 select ack");
        do_rstart();
        send_byte(8'h72, 1'b1, "R11 address after repeated start");
        chk("R12 busy across repeated start", bus_busy, 1);
        pair(8'h07, 8'h04);
        send_byte(8'h02, 1'b1, "R4 select ack");
        do_rstart();
        send_byte(8'h72, 1'b1, "R11 address ack");
        pair(8'h03, 8'h08);
        do_stop();
        chk("R11 pending select dropped", act_vec(), exp_vec());

        // R1 strap change after reset ignored
        strap = 1'b1; waitq(2);
        do_start();
        send_byte(8'h74, 1'b0, "R1 late strap ignored");
        do_stop();
        do_start();
        send_byte(8'h72, 1'b1, "R1 address kept");
        pair(8'h01, 8'h02);
        do_stop();
        chk("R1 write with kept address", act_vec(), exp_vec());

        // R1 strap high at reset, R10 reset again
        do_reset(1'b1);
        chk("R10 fields after reset", act_vec(), 0);
        chk("R10 powered_down after reset", powered_down, 1);
        d0 = n_dim;
        do_start();
        send_byte(8'h72, 1'b1 ^ 1'b1, "R1 low address refused");
        do_stop();
        do_start();
        send_byte(8'h75, 1'b1, "R1 high address ack (R2 read form)");
        pair(8'h04, 8'h0C);
        do_stop();
        chk("R1 high strap write", act_vec(), exp_vec());
        chk("R9 dim start", n_dim - d0, 1);

        done = 1;
    end

    initial begin : watchdog
        int cyc;
        cyc = 0;
        while (!done && cyc < 150000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog act=%0d exp=done", cyc);
        end
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule